// File: doc/BRIEF.md
# Conversion-Result Window Comparator

This block sits beside a multi-channel analog-to-digital converter and watches the stream of finished conversions. Every result arrives with a valid strobe, a channel number and a 12-bit sample. The block compares the sample against a programmable threshold pair. There are four compare conditions: below the low limit, above the high limit, inside the window, or outside it. It can watch one chosen channel or every channel. A programmable filter demands a run of consecutive qualifying results before a compare event is declared.

A declared event sets a sticky status flag. Reading the status word clears that flag. An enable bit gates the flag onto an interrupt line. Software programs the block through a small word-addressed read/write port. Reads are combinational and show the current register contents. Writes take effect at the clock edge.

Top module: `adcw_window_watch`

## Requirements
- R1: With compare mode code 0, a monitored result qualifies only when its value is strictly less than the low threshold.
- R2: With compare mode code 1, a monitored result qualifies only when its value is strictly greater than the high threshold.
- R3: With mode code 2, a result qualifies when low <= value <= high. With mode code 3, it qualifies when value < low or value > high.
- R4: Word 0 is the config word: mode in bits 1:0, selected channel in bits 7:4, compare-all in bit 9, filter in bits 13:12. Word 1 is the window word: low threshold in bits 11:0, high threshold in bits 27:16. Reading either word returns the stored fields, with all other bits zero.
- R5: With compare-all clear, only results whose channel equals the selected channel are monitored. Results on any other channel do not change the filter count.
- R6: With compare-all set, results on channels 0 to 11 are all monitored. Channel codes 12 to 15 are never monitored in either setting.
- R7: An event is declared on the filter+1-th consecutive qualifying monitored result. The count then restarts from zero. A non-qualifying monitored result resets the count to zero.
- R8: Status word 2 bit 26 is set by an event and stays set until word 2 is read. That read returns the flag and clears it, unless a new event arrives in the same cycle, in which case the flag stays set.
- R9: Word 3 bit 26 is the interrupt enable, and only that bit is stored. The irq output is high exactly when both the status flag and the enable are set.
- R10: Any write to word 0 or word 1 resets the filter count. A result presented in the same cycle as such a write is not counted.
- R11: After reset, all four words read as zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the status flag when the status word is read) |
| reg_addr | input | 2 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| res_vld | input | 1 | Conversion result valid |
| res_chan | input | 4 | Channel number of the result |
| res_data | input | 12 | Conversion value |
| irq | output | 1 | Compare-event interrupt |

## Verification
The bench builds the block with its default parameters: 12 channels, 4-bit channel codes, 12-bit samples and a 2-bit filter. The 4-bit channel code leaves codes 12 to 15 unused, so the out-of-range channel path can be reached. The 2-bit filter allows a run length of up to four, so the largest filter setting can be reached in a few cycles. Each threshold is probed exactly on the boundary and one count either side. This shows where the strict and the inclusive comparisons differ.

// File: rtl/adcw_pkg.sv
package adcw_pkg;

    localparam int DATA_W   = 12;
    localparam int CHAN_W   = 4;
    localparam int NUM_CHAN = 12;
    localparam int FILT_W   = 2;
    localparam int MODE_W   = 2;
    localparam int REG_W    = 32;
    localparam int ADDR_W   = 2;

    // field positions inside the register words
    localparam int CFG_MODE_LSB = 0;
    localparam int CFG_CHAN_LSB = 4;
    localparam int CFG_ALL_BIT  = 9;
    localparam int CFG_FILT_LSB = 12;
    localparam int WIN_LO_LSB   = 0;
    localparam int WIN_HI_LSB   = 16;
    localparam int EVT_BIT      = 26;

    typedef enum logic [MODE_W-1:0] {
        CMP_BELOW   = 2'd0,
        CMP_ABOVE   = 2'd1,
        CMP_INSIDE  = 2'd2,
        CMP_OUTSIDE = 2'd3
    } cmp_mode_e;

    typedef enum logic [ADDR_W-1:0] {
        WORD_CFG  = 2'd0,
        WORD_WIN  = 2'd1,
        WORD_STAT = 2'd2,
        WORD_IEN  = 2'd3
    } word_e;

    typedef struct packed {
        cmp_mode_e         mode;
        logic [CHAN_W-1:0] chan;
        logic              all;
        logic [FILT_W-1:0] filt;
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] hi;
    } cmp_cfg_t;

endpackage

// File: rtl/adcw_cfg_regs.sv
module adcw_cfg_regs
    import adcw_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [RW-1:0] wdata,
    output cmp_cfg_t      cfg,
    output logic          ien,
    output logic          cfg_wr
);

    typedef struct packed {
        cmp_cfg_t cfg;
        logic     ien;
    } regs_t;

    regs_t r_d, r_q;

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    always_comb begin
        r_d    = r_q;
        cfg_wr = 1'b0;
        if (wr) begin
            unique case (word_e'(addr))
                WORD_CFG: begin
                    r_d.cfg.mode = cmp_mode_e'(wdata[CFG_MODE_LSB +: MODE_W]);
                    r_d.cfg.chan = wdata[CFG_CHAN_LSB +: CHAN_W];
                    r_d.cfg.all  = wdata[CFG_ALL_BIT];
                    r_d.cfg.filt = wdata[CFG_FILT_LSB +: FILT_W];
                    cfg_wr       = 1'b1;
                end
                WORD_WIN: begin
                    r_d.cfg.lo = wdata[WIN_LO_LSB +: DATA_W];
                    r_d.cfg.hi = wdata[WIN_HI_LSB +: DATA_W];
                    cfg_wr     = 1'b1;
                end
                WORD_IEN: r_d.ien = wdata[EVT_BIT];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cfg = r_q.cfg;
    assign ien = r_q.ien;

endmodule

// File: rtl/adcw_match.sv
module adcw_match
    import adcw_pkg::*;
#(
    parameter int NCH = NUM_CHAN,
    parameter int CW  = CHAN_W,
    parameter int DW  = DATA_W
) (
    input  cmp_cfg_t      cfg,
    input  logic          vld,
    input  logic [CW-1:0] chan,
    input  logic [DW-1:0] data,
    output logic          monitored,
    output logic          qualify
);

    localparam int SLOTS = 1 << CW;

    logic [SLOTS-1:0] elig;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        if (i < NCH) begin : g_real
            assign elig[i] = cfg.all || (cfg.chan == CW'(i));
        end else begin : g_void
            assign elig[i] = 1'b0;
        end
    end

    assign monitored = vld && elig[chan];

    logic below_lo, above_hi;
    assign below_lo = data < cfg.lo;
    assign above_hi = data > cfg.hi;

    always_comb begin
        unique case (cfg.mode)
            CMP_BELOW:   qualify = below_lo;
            CMP_ABOVE:   qualify = above_hi;
            CMP_INSIDE:  qualify = !below_lo && !above_hi;
            CMP_OUTSIDE: qualify = below_lo || above_hi;
            default:     qualify = 1'b0;
        endcase
    end

endmodule

// File: rtl/adcw_filter.sv
module adcw_filter
    import adcw_pkg::*;
#(
    parameter int FW = FILT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          seen,
    input  logic          hit,
    input  logic [FW-1:0] need,
    output logic          fire,
    output logic [FW-1:0] cnt
);

    logic [FW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        fire  = 1'b0;
        if (clear) begin
            cnt_d = '0;
        end else if (seen) begin
            if (!hit) begin
                cnt_d = '0;
            end else if (cnt_q == need) begin
                fire  = 1'b1;
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/adcw_window_watch.sv
module adcw_window_watch
    import adcw_pkg::*;
#(
    parameter int NCH = NUM_CHAN,
    parameter int CW  = CHAN_W,
    parameter int DW  = DATA_W,
    parameter int FW  = FILT_W,
    parameter int RW  = REG_W,
    parameter int AW  = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [RW-1:0] reg_wdata,
    output logic [RW-1:0] reg_rdata,
    input  logic          res_vld,
    input  logic [CW-1:0] res_chan,
    input  logic [DW-1:0] res_data,
    output logic          irq
);

    cmp_cfg_t      cfg;
    logic          ien, cfg_wr;
    logic          monitored, qualify, fire;
    logic [FW-1:0] cnt;
    logic          stat_rd;

    adcw_cfg_regs #(.RW(RW), .AW(AW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .cfg    (cfg),
        .ien    (ien),
        .cfg_wr (cfg_wr)
    );

    adcw_match #(.NCH(NCH), .CW(CW), .DW(DW)) u_match (
        .cfg       (cfg),
        .vld       (res_vld),
        .chan      (res_chan),
        .data      (res_data),
        .monitored (monitored),
        .qualify   (qualify)
    );

    adcw_filter #(.FW(FW)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cfg_wr),
        .seen  (monitored),
        .hit   (qualify),
        .need  (cfg.filt),
        .fire  (fire),
        .cnt   (cnt)
    );

    typedef struct packed {
        logic evt;
    } stat_t;

    stat_t s_d, s_q;

    assign stat_rd = reg_rd && (word_e'(reg_addr) == WORD_STAT);

    always_comb begin
        s_d = s_q;
        if (stat_rd) s_d.evt = 1'b0;
        if (fire)    s_d.evt = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (word_e'(reg_addr))
            WORD_CFG: begin
                reg_rdata[CFG_MODE_LSB +: MODE_W] = cfg.mode;
                reg_rdata[CFG_CHAN_LSB +: CW]     = cfg.chan;
                reg_rdata[CFG_ALL_BIT]            = cfg.all;
                reg_rdata[CFG_FILT_LSB +: FW]     = cfg.filt;
            end
            WORD_WIN: begin
                reg_rdata[WIN_LO_LSB +: DW] = cfg.lo;
                reg_rdata[WIN_HI_LSB +: DW] = cfg.hi;
            end
            WORD_STAT: reg_rdata[EVT_BIT] = s_q.evt;
            WORD_IEN:  reg_rdata[EVT_BIT] = ien;
            default: ;
        endcase
    end

    assign irq = s_q.evt && ien;

endmodule

// File: rtl/adcw_chk.sv
module adcw_chk
    import adcw_pkg::*;
#(
    parameter int NCH = NUM_CHAN,
    parameter int CW  = CHAN_W,
    parameter int FW  = FILT_W,
    parameter int AW  = ADDR_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [AW-1:0] reg_addr,
    input logic [CW-1:0] res_chan,
    input logic          monitored,
    input logic          qualify,
    input logic          fire,
    input logic          cfg_wr,
    input logic [FW-1:0] cnt,
    input logic [FW-1:0] filt,
    input logic          evt,
    input logic          irq
);

    logic ien_wr, stat_rd;
    assign ien_wr  = reg_wr && (reg_addr == AW'(WORD_IEN));
    assign stat_rd = reg_rd && (reg_addr == AW'(WORD_STAT));

    // R7: an event only comes from a qualifying monitored result
    a_r7_fire_from_hit: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (monitored && qualify));

    // R7: the run count never passes the filter setting
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= filt);

    // R10: a config or window write leaves the count at zero
    a_r10_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cnt == '0));

    // R8: an event sets the flag
    a_r8_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> evt);

    // R8: the flag holds until the status word is read
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !stat_rd) |=> evt);

    // R9: irq only rises after an event or an enable write
    a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(fire) || $past(ien_wr)));

    // R6: unused channel codes are never monitored
    a_r6_no_void_chan: assert property (@(posedge clk) disable iff (!rst_n)
        monitored |-> (res_chan < CW'(NCH)));

endmodule

bind adcw_window_watch adcw_chk #(.NCH(NCH), .CW(CW), .FW(FW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .res_chan  (res_chan),
    .monitored (monitored),
    .qualify   (qualify),
    .fire      (fire),
    .cfg_wr    (cfg_wr),
    .cnt       (cnt),
    .filt      (cfg.filt),
    .evt       (s_q.evt),
    .irq       (irq)
);

// File: tb/sim_adcw_window_watch.sv
`timescale 1ns/1ps
module sim_adcw_window_watch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        res_vld = 1'b0;
    logic [3:0]  res_chan = '0;
    logic [11:0] res_data = '0;
    logic        irq;

    int tests = 0, fails = 0;
    logic [31:0] v;

    always #2.5 clk = ~clk;

    adcw_window_watch u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .res_vld(res_vld), .res_chan(res_chan), .res_data(res_data), .irq(irq)
    );

    localparam logic [31:0] EVT  = 32'h0400_0000;
    localparam logic [31:0] WIN0 = 32'h00C8_0064; // low 100, high 200

    typedef struct packed {
        logic [31:0] cfg;
        logic [31:0] win;
        logic [3:0]  ch;
        logic [11:0] d;
        logic        hit;
    } vec_t;

    localparam vec_t VEC [15] = '{
        '{32'h0030, WIN0, 4'd3, 12'd99, 1'b1},          // R1 below low
        '{32'h0030, WIN0, 4'd3, 12'd100, 1'b0},         // R1 equal low
        '{32'h0031, WIN0, 4'd3, 12'd201, 1'b1},         // R2 above high
        '{32'h0031, WIN0, 4'd3, 12'd200, 1'b0},         // R2 equal high
        '{32'h0032, WIN0, 4'd3, 12'd100, 1'b1},         // R3 inside at low
        '{32'h0032, WIN0, 4'd3, 12'd200, 1'b1},         // R3 inside at high
        '{32'h0032, WIN0, 4'd3, 12'd99, 1'b0},          // R3 just outside
        '{32'h0033, WIN0, 4'd3, 12'd201, 1'b1},         // R3 outside
        '{32'h0033, WIN0, 4'd3, 12'd150, 1'b0},         // R3 not outside
        '{32'h0030, WIN0, 4'd5, 12'd0, 1'b0},           // R5 other channel
        '{32'h0230, WIN0, 4'd5, 12'd0, 1'b1},           // R6 all channels
        '{32'h0230, WIN0, 4'd11, 12'd0, 1'b1},          // R6 top channel
        '{32'h0230, WIN0, 4'd12, 12'd0, 1'b0},          // R6 void code
        '{32'h00B0, WIN0, 4'd11, 12'd0, 1'b1},          // R5 select 11
        '{32'h0233, 32'h0FFF_0000, 4'd0, 12'hFFF, 1'b0} // R3 full window
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic res(input logic [3:0] c, input logic [11:0] d);
        res_vld = 1'b1; res_chan = c; res_data = d;
        @(posedge clk); #1;
        res_vld = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R11 reset word", v, 32'h0);
        end
        check("R11 reset irq", {31'b0, irq}, 32'h0);

        // table of single-result cases, filter 0
        for (int i = 0; i < 15; i++) begin
            wr(2'd0, VEC[i].cfg);
            wr(2'd1, VEC[i].win);
            rd(2'd2, v);
            res(VEC[i].ch, VEC[i].d);
            rd(2'd2, v);
            check($sformatf("R1 R2 R3 R5 R6 vector %0d", i), v & EVT,
                  VEC[i].hit ? EVT : 32'h0);
        end

        // R4 readback masks
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v); check("R4 config readback", v, 32'h0000_32F3);
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); check("R4 window readback", v, 32'h0FFF_0FFF);

        // R7 filter 2: three hits needed, a miss restarts
        wr(2'd1, WIN0);
        wr(2'd0, 32'h2030);
        rd(2'd2, v);
        res(4'd3, 12'd0); res(4'd3, 12'd0);
        rd(2'd2, v); check("R7 two of three", v, 32'h0);
        res(4'd3, 12'd0);
        rd(2'd2, v); check("R7 third hit", v, EVT);
        res(4'd3, 12'd0); res(4'd3, 12'd0); res(4'd3, 12'd150);
        res(4'd3, 12'd0); res(4'd3, 12'd0);
        rd(2'd2, v); check("R7 miss restarts", v, 32'h0);
        res(4'd3, 12'd0);
        rd(2'd2, v); check("R7 run after miss", v, EVT);

        // R7 filter 3: four hits
        wr(2'd0, 32'h3030);
        res(4'd3, 12'd0); res(4'd3, 12'd0); res(4'd3, 12'd0);
        rd(2'd2, v); check("R7 three of four", v, 32'h0);
        res(4'd3, 12'd0);
        rd(2'd2, v); check("R7 fourth hit", v, EVT);

        // R5 other channel does not break a run
        wr(2'd0, 32'h1030);
        res(4'd3, 12'd0); res(4'd5, 12'd150); res(4'd3, 12'd0);
        rd(2'd2, v); check("R5 other channel ignored", v, EVT);

        // R8 sticky and clear on read
        wr(2'd0, 32'h0030);
        res(4'd3, 12'd0); res(4'd3, 12'd150);
        rd(2'd2, v); check("R8 held over miss", v, EVT);
        rd(2'd2, v); check("R8 cleared by read", v, 32'h0);

        // R8 event in the same cycle as the clearing read
        res_vld = 1'b1; res_chan = 4'd3; res_data = 12'd0;
        reg_rd = 1'b1; reg_addr = 2'd2;
        #1 v = reg_rdata;
        check("R8 read before set", v, 32'h0);
        @(posedge clk); #1;
        res_vld = 1'b0; reg_rd = 1'b0;
        rd(2'd2, v); check("R8 set wins over clear", v, EVT);

        // R9 interrupt gating
        res(4'd3, 12'd0);
        check("R9 irq masked", {31'b0, irq}, 32'h0);
        wr(2'd3, 32'hFFFF_FFFF);
        check("R9 irq enabled", {31'b0, irq}, 32'h1);
        rd(2'd3, v); check("R9 enable readback", v, EVT);
        rd(2'd2, v);
        check("R9 irq after clear", {31'b0, irq}, 32'h0);
        wr(2'd3, 32'h0);

        // R10 window write restarts the run
        wr(2'd0, 32'h1030);
        res(4'd3, 12'd0);
        wr(2'd1, WIN0);
        res(4'd3, 12'd0);
        rd(2'd2, v); check("R10 write restarts run", v, 32'h0);
        res(4'd3, 12'd0);
        rd(2'd2, v); check("R10 run after write", v, EVT);

        // R10 result in the write cycle is dropped
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h0030;
        res_vld = 1'b1; res_chan = 4'd3; res_data = 12'd0;
        @(posedge clk); #1;
        reg_wr = 1'b0; res_vld = 1'b0;
        rd(2'd2, v); check("R10 same-cycle result dropped", v, 32'h0);

        finish_run();
    end

endmodule